// File: doc/BRIEF.md
# PCIe Root Port Reset Sequencer

This block brings a PCIe root-port controller out of reset without firmware timing loops. A start request drives all four active-low controller resets low, puts the controller into root-complex mode and masks its legacy INTx interrupts. The block then holds PERST# long enough to meet the fundamental-reset hold time measured from power-up, and releases the four resets together. After the release it samples the MAC's link-up flag at a fixed microsecond interval for a bounded number of attempts.

The caller may state how many microseconds have already passed since PERST# was first asserted. In that case only the shortfall to the hold time is waited. If no such time is known, the full hold time is waited. Once the sequence ends, the block reports success or failure and the number of samples it took. It also keeps the LTSSM state code seen at that moment, and flags the code when it lies outside the defined range. Time is counted from a one-cycle microsecond tick supplied from outside the block.

Top module: `pcie_rp_reset_seq`

## Requirements
- R1: A synchronous reset (rst high) leaves the block idle with rst_n_o = 4'b0000, rc_mode_o = 0, intx_en_o = 4'b1111, busy_o = 0, done_o = 0, link_ok_o = 0 and fail_o = 0.
- R2: An accepted start drives rst_n_o to 4'b0000 in the following cycle. Before any reset is released, rc_mode_o is 1 and intx_en_o is 4'b0000.
- R3: The wait before release is HOLD_US - elapsed_us_i when elapsed_vld_i = 1 and elapsed_us_i < HOLD_US, zero when elapsed_vld_i = 1 and elapsed_us_i >= HOLD_US, and HOLD_US when elapsed_vld_i = 0. Both inputs are taken at the start. The wait counts us_tick_i pulses. With a tick in every cycle, a wait of w leaves the resets released after the (w+3)-th rising edge, counting the start edge as the first.
- R4: The resets change only as a group. rst_n_o is always 4'b0000 or 4'b1111, with bit 0 the MAC reset, bit 1 the PHY reset, bit 2 the bridge reset and bit 3 PERST#.
- R5: Link-up is bit 8 of link_status_i. It is sampled in the cycle after release, and again each time POLL_US ticks have been counted after the previous sample. The first sample that sees it set ends the sequence with link_ok_o = 1 and tries_o equal to the number of samples taken.
- R6: If MAX_TRIES samples all see link-up clear, the sequence ends with fail_o = 1 and tries_o = MAX_TRIES, and the resets stay released.
- R7: At the end of every sequence, ltssm_o captures bits 28:24 of ltssm_status_i. ltssm_unknown_o is 1 exactly when that code is above 5'h1A.
- R8: done_o is high for exactly one cycle when a sequence ends, and busy_o falls in that same cycle. busy_o is high from the cycle after an accepted start until then.
- R9: A start request while busy_o is high is ignored. It changes neither the wait nor the outcome of the sequence already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| start_i | input | 1 | Request to run the sequence |
| elapsed_vld_i | input | 1 | elapsed_us_i holds a known PERST# time |
| elapsed_us_i | input | 32 | Microseconds since PERST# was asserted |
| link_status_i | input | 32 | MAC link status word, link-up in bit 8 |
| ltssm_status_i | input | 32 | MAC LTSSM status word, state in bits 28:24 |
| rst_n_o | output | 4 | Active-low resets: MAC, PHY, bridge, PERST# |
| rc_mode_o | output | 1 | Root-complex mode select |
| intx_en_o | output | 4 | INTx interrupt enables |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| link_ok_o | output | 1 | Last sequence saw the link come up |
| fail_o | output | 1 | Last sequence ran out of samples |
| tries_o | output | $clog2(MAX_TRIES+1) | Link samples taken in the last sequence |
| ltssm_o | output | 5 | LTSSM code captured at the end |
| ltssm_unknown_o | output | 1 | Captured code is above 5'h1A |

## Verification
The hold stage is driven with no known elapsed time, with elapsed times below, equal to and above the hold time, and with random values between them. The measured release cycle separates the three ways the wait is computed. The polling stage is driven with a link that is up at once, a link that never comes up, and a link that rises after a random number of failed samples. These runs show whether the first sample comes in the cycle after release, how far apart later samples are, and how tries are counted. LTSSM codes at 0x10, at 0x1A, just above 0x1A and random values test the capture and the unknown flag. A second start pulse in the middle of a sequence, and a reset in the middle of a hold, check that a running sequence cannot be disturbed except by reset.

// File: rtl/pcie_rp_pkg.sv
package pcie_rp_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CFG  = 2'd1,
    S_HOLD = 2'd2,
    S_POLL = 2'd3
  } seq_state_e;

  localparam logic [4:0] LTSSM_LAST_CODE = 5'h1A;

  // Shortfall still to wait before the resets may be released.
  function automatic logic [31:0] hold_remaining(input logic        known,
                                                 input logic [31:0] elapsed,
                                                 input logic [31:0] hold);
    if (!known)              return hold;
    else if (elapsed >= hold) return 32'd0;
    else                     return hold - elapsed;
  endfunction

  function automatic logic ltssm_known(input logic [4:0] code);
    return code <= LTSSM_LAST_CODE;
  endfunction

endpackage

// File: rtl/rp_us_timer.sv
module rp_us_timer #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != CMAX) cnt <= cnt + 1'b1;
  end

  // R3: the microsecond count never wraps back to zero
  p_timer_sat_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == CMAX) |=> (cnt == CMAX));

endmodule

// File: rtl/rp_result_cap.sv
module rp_result_cap
  import pcie_rp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       fin_ok,
  input  logic       fin_fail,
  input  logic [4:0] code,
  output logic       link_ok_o,
  output logic       fail_o,
  output logic [4:0] ltssm_o,
  output logic       unknown_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      link_ok_o <= 1'b0;
      fail_o    <= 1'b0;
      ltssm_o   <= '0;
      unknown_o <= 1'b0;
    end else if (clr) begin
      link_ok_o <= 1'b0;
      fail_o    <= 1'b0;
    end else if (fin_ok || fin_fail) begin
      link_ok_o <= fin_ok;
      fail_o    <= fin_fail;
      ltssm_o   <= code;
      unknown_o <= !ltssm_known(code);
    end
  end

  // R5/R6: an outcome is either success or failure, never both
  p_outcome_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(link_ok_o && fail_o));

  // R7: a captured code keeps its value until the next end of sequence
  p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(fin_ok || fin_fail) |=> $stable(ltssm_o));

endmodule

// File: rtl/pcie_rp_reset_seq.sv
module pcie_rp_reset_seq
  import pcie_rp_pkg::*;
#(
  parameter int HOLD_US   = 100000,
  parameter int POLL_US   = 1000,
  parameter int MAX_TRIES = 100,
  localparam int TW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          us_tick_i,
  input  logic          start_i,
  input  logic          elapsed_vld_i,
  input  logic [31:0]   elapsed_us_i,
  input  logic [31:0]   link_status_i,
  input  logic [31:0]   ltssm_status_i,
  output logic [3:0]    rst_n_o,
  output logic          rc_mode_o,
  output logic [3:0]    intx_en_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          link_ok_o,
  output logic          fail_o,
  output logic [TW-1:0] tries_o,
  output logic [4:0]    ltssm_o,
  output logic          ltssm_unknown_o
);

  localparam int CMAX = (HOLD_US > POLL_US) ? HOLD_US : POLL_US;
  localparam int CW   = $clog2(CMAX + 2);

  seq_state_e    state_q;
  logic [CW-1:0] remain_q;
  logic [TW-1:0] tries_q;
  logic [3:0]    rst_n_q;
  logic          rc_mode_q;
  logic [3:0]    intx_q;
  logic          done_q;

  // Named internal events
  logic          link_up;
  logic [4:0]    ltssm_code;
  logic          start_acc;
  logic          hold_over;
  logic          sample_now;
  logic          last_try;
  logic          finish_ok;
  logic          finish_fail;
  logic          tmr_load;
  logic [CW-1:0] tmr_load_val;
  logic [CW-1:0] tmr_cnt;
  logic          unused_bits;

  assign link_up     = link_status_i[8];
  assign ltssm_code  = ltssm_status_i[28:24];
  assign unused_bits = ^{link_status_i[31:9], link_status_i[7:0],
                         ltssm_status_i[31:29], ltssm_status_i[23:0]};

  assign start_acc   = (state_q == S_IDLE) && start_i;
  assign hold_over   = (state_q == S_HOLD) && (tmr_cnt >= remain_q);
  assign sample_now  = (state_q == S_POLL) && (tmr_cnt >= CW'(POLL_US));
  assign last_try    = (tries_q == TW'(MAX_TRIES - 1));
  assign finish_ok   = sample_now && link_up;
  assign finish_fail = sample_now && !link_up && last_try;

  assign tmr_load     = (state_q == S_CFG) || hold_over ||
                        (sample_now && !finish_ok && !finish_fail);
  assign tmr_load_val = hold_over ? CW'(POLL_US) : '0;

  rp_us_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .tick     (us_tick_i),
    .cnt      (tmr_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      remain_q  <= '0;
      tries_q   <= '0;
      rst_n_q   <= 4'b0000;
      rc_mode_q <= 1'b0;
      intx_q    <= 4'b1111;
      done_q    <= 1'b0;
    end else begin
      done_q <= finish_ok || finish_fail;
      unique case (state_q)
        S_IDLE: if (start_acc) begin
          state_q  <= S_CFG;
          rst_n_q  <= 4'b0000;
          tries_q  <= '0;
          remain_q <= CW'(hold_remaining(elapsed_vld_i, elapsed_us_i,
                                         32'(HOLD_US)));
        end
        S_CFG: begin
          rc_mode_q <= 1'b1;
          intx_q    <= 4'b0000;
          state_q   <= S_HOLD;
        end
        S_HOLD: if (hold_over) begin
          rst_n_q <= 4'b1111;
          state_q <= S_POLL;
        end
        S_POLL: if (sample_now) begin
          tries_q <= tries_q + 1'b1;
          if (finish_ok || finish_fail) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  rp_result_cap u_result (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_acc),
    .fin_ok    (finish_ok),
    .fin_fail  (finish_fail),
    .code      (ltssm_code),
    .link_ok_o (link_ok_o),
    .fail_o    (fail_o),
    .ltssm_o   (ltssm_o),
    .unknown_o (ltssm_unknown_o)
  );

  assign rst_n_o   = rst_n_q;
  assign rc_mode_o = rc_mode_q;
  assign intx_en_o = intx_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign tries_o   = tries_q;

  // R4: resets move only as a group
  p_rst_group_r4: assert property (@(posedge clk) disable iff (rst)
    (rst_n_o == 4'b0000) || (rst_n_o == 4'b1111));

  // R2: configuration is in place when the resets are released
  p_cfg_first_r2: assert property (@(posedge clk) disable iff (rst)
    (rst_n_o == 4'b1111 && $past(rst_n_o) == 4'b0000)
      |-> (rc_mode_o && intx_en_o == 4'b0000));

  // R8: done is a single-cycle pulse, seen with busy already low
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R6: the sample count never exceeds its bound; failure means all used
  p_tries_bound_r6: assert property (@(posedge clk) disable iff (rst)
    tries_o <= TW'(MAX_TRIES));
  p_fail_count_r6: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (tries_o == TW'(MAX_TRIES)));

  // R9: a start seen while busy leaves the latched wait untouched
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(remain_q));

endmodule

// File: tb/pcie_rp_reset_seq_test.sv
module pcie_rp_reset_seq_test;

  localparam int HOLD  = 300;
  localparam int POLL  = 8;
  localparam int MAXT  = 6;
  localparam int TW    = $clog2(MAXT + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b1;
  logic          start = 1'b0;
  logic          evld = 1'b0;
  logic [31:0]   eus = '0;
  logic [31:0]   lstat = '0;
  logic [31:0]   sstat = '0;
  logic [3:0]    rst_n;
  logic          rc_mode;
  logic [3:0]    intx_en;
  logic          busy, done, link_ok, fail, unk;
  logic [TW-1:0] tries;
  logic [4:0]    ltssm;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcie_rp_reset_seq #(.HOLD_US(HOLD), .POLL_US(POLL), .MAX_TRIES(MAXT)) uut (
    .clk(clk), .rst(rst), .us_tick_i(tick), .start_i(start),
    .elapsed_vld_i(evld), .elapsed_us_i(eus),
    .link_status_i(lstat), .ltssm_status_i(sstat),
    .rst_n_o(rst_n), .rc_mode_o(rc_mode), .intx_en_o(intx_en),
    .busy_o(busy), .done_o(done), .link_ok_o(link_ok), .fail_o(fail),
    .tries_o(tries), .ltssm_o(ltssm), .ltssm_unknown_o(unk));

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_wait(input bit known, input int el);
    if (!known) return HOLD;
    if (el >= HOLD) return 0;
    return HOLD - el;
  endfunction

  // mode 0: link never up; 1: up at once; 2: up after `downs` failed samples
  task automatic run_seq(input bit known, input int el, input int mode,
                         input int downs, input logic [4:0] code,
                         input bit glitch);
    int n = 0;
    int rel = 0;
    int w = exp_wait(known, el);
    int exp_tries;
    int exp_done;
    bit seen_done = 0;
    @(negedge clk);
    evld  = known;
    eus   = el;
    lstat = (mode == 1) ? 32'h0000_0100 : 32'h0000_0000;
    lstat[20] = 1'b1;                 // a neighbouring bit that must not count
    sstat = {3'b010, code, 24'hABCDEF};
    start = 1'b1;
    exp_tries = (mode == 0) ? MAXT : (mode == 1) ? 1 : downs + 1;
    exp_done  = w + 3 + 1 + (exp_tries - 1) * (POLL + 1);
    while (n < 5000) begin
      @(posedge clk);
      n++;
      #1;
      if (n == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        chk(rst_n == 4'b0000, "R2 resets low after start", rst_n, 0);
      end
      if (glitch && n == 4) begin
        start = 1'b1; evld = 1'b1; eus = HOLD + 5;
      end
      if (glitch && n == 5) start = 1'b0;
      if (rel == 0 && rst_n == 4'b1111) begin
        rel = n;
        chk(rc_mode == 1'b1 && intx_en == 4'b0000,
            "R2 config before release", {rc_mode, intx_en}, 5'b10000);
      end
      if (mode == 2 && rel != 0 && n == rel + 1 + (downs - 1) * (POLL + 1))
        lstat[8] = 1'b1;
      if (done) begin
        seen_done = 1;
        break;
      end
    end
    chk(seen_done, "R8 watchdog done seen", seen_done, 1);
    chk(rel == w + 3, glitch ? "R9 release time kept" : "R3 release time",
        rel, w + 3);
    chk(n == exp_done, "R5 end time", n, exp_done);
    chk(busy == 1'b0, "R8 busy low with done", busy, 0);
    chk(tries == TW'(exp_tries), "R5 R6 tries", tries, exp_tries);
    if (mode == 0) begin
      chk(fail == 1'b1 && link_ok == 1'b0, "R6 failure flagged",
          {fail, link_ok}, 2'b10);
      chk(rst_n == 4'b1111, "R6 resets stay released", rst_n, 15);
    end else begin
      chk(link_ok == 1'b1 && fail == 1'b0, "R5 success flagged",
          {link_ok, fail}, 2'b10);
    end
    chk(ltssm == code, "R7 code capture", ltssm, code);
    chk(unk == (code > 5'h1A), "R7 unknown flag", unk, code > 5'h1A);
    @(posedge clk); #1;
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(rst_n == 4'b0000 || rst_n == 4'b1111, "R4 group", rst_n, 15);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk(rst_n == 4'b0000, "R1 reset outputs", rst_n, 0);
    chk(rc_mode == 1'b0 && intx_en == 4'b1111, "R1 reset config",
        {rc_mode, intx_en}, 5'b01111);
    chk(!busy && !done && !link_ok && !fail, "R1 reset status",
        {busy, done, link_ok, fail}, 0);
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    run_seq(1'b0, 0,        1, 0, 5'h10, 1'b0);   // R3 full hold
    run_seq(1'b1, 100,      0, 0, 5'h10, 1'b0);   // R3 shortfall, R6
    run_seq(1'b1, HOLD,     1, 0, 5'h1A, 1'b0);   // R3 exactly met
    run_seq(1'b1, HOLD + 77, 0, 0, 5'h1B, 1'b0);  // R3 exceeded, R7 unknown
    run_seq(1'b1, HOLD - 1, 2, 3, 5'h1F, 1'b0);   // R5 late link
    run_seq(1'b1, 40,       1, 0, 5'h02, 1'b1);   // R9 mid-run start

    // random mix
    for (int i = 0; i < 10; i++) begin
      bit known = $urandom_range(0, 3) != 0;
      int el    = $urandom_range(0, HOLD + 50);
      int mode  = $urandom_range(0, 2);
      int downs = $urandom_range(1, MAXT - 1);
      logic [4:0] code = 5'($urandom_range(0, 31));
      run_seq(known, el, mode, downs, code, 1'b0);
    end

    // R1: reset in the middle of a hold
    @(negedge clk);
    evld = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk(rst_n == 4'b0000 && !busy, "R1 reset mid-sequence",
        {rst_n, busy}, 0);
    chk(rc_mode == 1'b0 && intx_en == 4'b1111, "R1 config after reset",
        {rc_mode, intx_en}, 5'b01111);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule